// File: doc/BRIEF.md
# Synchronous Burst SRAM Core

A single-port synchronous SRAM with words made of two 9-bit byte lanes. Each lane carries eight data bits and one parity bit. Address, write data, the write controls and three chip selects are captured on each rising clock edge. An external burst sequencer supplies every address, so the core only sees single-beat commands. A selected cycle with no lane enabled for writing is a read. The read word is registered and appears one cycle after its address is captured.

Writes are layered. A global write stores both lanes. Otherwise each lane can be written on its own, but only while the byte-write enable is asserted. A captured write is held in a one-entry buffer and committed to the array one cycle later. A read of that address in the following cycle takes the newly written lanes from the buffer and the untouched lanes from the array.

The output stage produces a registered data word and a drive enable for an external tristate buffer. The drive enable is asserted only after a selected read, and the asynchronous output enable gates it. A deselect therefore floats the bus in the second cycle, without a wait state between devices.

Top module: `sync_burst_sram`

## Requirements
- R1: After reset, dout_en_o is low and dout_o is zero.
- R2: Lane 0 is dout/din bits [8:0] and lane 1 is bits [17:9]. With gw_n_i high and bwe_n_i low, lane_we_n_i[i] low writes lane i only, and the other lane keeps its old value.
- R3: With gw_n_i and bwe_n_i both high, lane_we_n_i has no effect. No lane is written and the cycle is a read.
- R4: gw_n_i low writes both lanes, whatever bwe_n_i and lane_we_n_i are.
- R5: A selected read captured at edge k puts the word stored at its address on dout_o after edge k+1. dout_en_o is high from then on while oe_n_i is low. Back-to-back reads give one word per cycle.
- R6: A read that immediately follows a write to the same address returns the written lanes merged with the old contents of the unwritten lanes. A read of a different address is not affected by the pending write.
- R7: The device is selected only when sel_a_n_i=0, sel_b_n_i=0 and sel_c_i=1. Writes attempted while deselected leave the array unchanged.
- R8: A deselect captured at edge k makes dout_en_o low after edge k+1.
- R9: For a write captured at edge k, dout_en_o is low after edge k+1 and dout_o holds the last read word.
- R10: oe_n_i high forces dout_en_o low at once, without a clock edge. oe_n_i low restores the drive enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Word address |
| din_i | input | LANES*LANE_W | Write data |
| sel_a_n_i | input | 1 | Chip select A, active low |
| sel_b_n_i | input | 1 | Chip select B, active low |
| sel_c_i | input | 1 | Chip select C, active high |
| gw_n_i | input | 1 | Global write, active low |
| bwe_n_i | input | 1 | Byte-write enable, active low |
| lane_we_n_i | input | LANES | Per-lane write enables, active low |
| oe_n_i | input | 1 | Asynchronous output enable, active low |
| dout_o | output | LANES*LANE_W | Registered read word |
| dout_en_o | output | 1 | Drive enable for the external data tristate |

## Verification
The array is first filled with global writes that have the lane enables deasserted, and then read back in full. This separates global-write override from lane gating. A sweep over every combination of lane enable and byte-write enable shows which lanes each combination stores. Write-then-read pairs to the same address and to a neighbouring address distinguish correct lane-merged pass-through from stale reads and from false forwarding. Each chip select is dropped in turn during attempted writes and reads to test selection and the two-cycle float. Toggling the output enable between edges tests its asynchronous path.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  typedef enum logic [1:0] {
    CMD_IDLE  = 2'd0,
    CMD_READ  = 2'd1,
    CMD_WRITE = 2'd2
  } sbs_cmd_e;
endpackage

// File: rtl/sbs_capture.sv
module sbs_capture import sbs_pkg::*; #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9,
  localparam int WORD_W = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] din_i,
  input  logic              sel_a_n_i,
  input  logic              sel_b_n_i,
  input  logic              sel_c_i,
  input  logic              gw_n_i,
  input  logic              bwe_n_i,
  input  logic [LANES-1:0]  lane_we_n_i,
  output logic [ADDR_W-1:0] addr_q_o,
  output logic [WORD_W-1:0] din_q_o,
  output logic [LANES-1:0]  wmask_q_o,
  output sbs_cmd_e          cmd_q_o
);
  logic              sel_a_n_q, sel_b_n_q, sel_c_q;
  logic              gw_n_q, bwe_n_q;
  logic [LANES-1:0]  lane_n_q;
  logic              selected;
  logic [LANES-1:0]  wmask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_a_n_q <= 1'b1;
      sel_b_n_q <= 1'b1;
      sel_c_q   <= 1'b0;
      gw_n_q    <= 1'b1;
      bwe_n_q   <= 1'b1;
      lane_n_q  <= '1;
      addr_q_o  <= '0;
      din_q_o   <= '0;
    end else begin
      sel_a_n_q <= sel_a_n_i;
      sel_b_n_q <= sel_b_n_i;
      sel_c_q   <= sel_c_i;
      gw_n_q    <= gw_n_i;
      bwe_n_q   <= bwe_n_i;
      lane_n_q  <= lane_we_n_i;
      addr_q_o  <= addr_i;
      din_q_o   <= din_i;
    end
  end

  assign selected = !sel_a_n_q && !sel_b_n_q && sel_c_q;

  // global write wins; lane enables only count under byte-write enable
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign wmask[g] = selected && (!gw_n_q || (!bwe_n_q && !lane_n_q[g]));
  end

  assign wmask_q_o = wmask;

  always_comb begin
    if (!selected)   cmd_q_o = CMD_IDLE;
    else if (|wmask) cmd_q_o = CMD_WRITE;
    else             cmd_q_o = CMD_READ;
  end
endmodule

// File: rtl/sbs_array.sv
module sbs_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9,
  localparam int WORD_W = LANES * LANE_W,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [LANES-1:0]  wmask_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [WORD_W-1:0] rdata_o
);
  logic [WORD_W-1:0] mem [DEPTH];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk_i) begin
      if (we_i && wmask_i[g])
        mem[waddr_i][g*LANE_W +: LANE_W] <= wdata_i[g*LANE_W +: LANE_W];
    end
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/sbs_wbuf.sv
module sbs_wbuf #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9,
  localparam int WORD_W = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic [LANES-1:0]  mask_i,
  output logic              pend_vld_o,
  output logic [ADDR_W-1:0] pend_addr_o,
  output logic [WORD_W-1:0] pend_data_o,
  output logic [LANES-1:0]  pend_mask_o,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [WORD_W-1:0] arr_word_i,
  output logic [WORD_W-1:0] rd_word_o
);
  logic hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_vld_o  <= 1'b0;
      pend_addr_o <= '0;
      pend_data_o <= '0;
      pend_mask_o <= '0;
    end else begin
      pend_vld_o <= load_i;
      if (load_i) begin
        pend_addr_o <= addr_i;
        pend_data_o <= data_i;
        pend_mask_o <= mask_i;
      end
    end
  end

  // pending entry commits at the same edge the read samples the array
  assign hit = pend_vld_o && (pend_addr_o == rd_addr_i);

  for (genvar g = 0; g < LANES; g++) begin : g_merge
    assign rd_word_o[g*LANE_W +: LANE_W] = (hit && pend_mask_o[g])
        ? pend_data_o[g*LANE_W +: LANE_W]
        : arr_word_i[g*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram import sbs_pkg::*; #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9,
  localparam int WORD_W = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] din_i,
  input  logic              sel_a_n_i,
  input  logic              sel_b_n_i,
  input  logic              sel_c_i,
  input  logic              gw_n_i,
  input  logic              bwe_n_i,
  input  logic [LANES-1:0]  lane_we_n_i,
  input  logic              oe_n_i,
  output logic [WORD_W-1:0] dout_o,
  output logic              dout_en_o
);
  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] din_q;
  logic [LANES-1:0]  wmask_q;
  sbs_cmd_e          cmd_q;
  logic              pend_vld;
  logic [ADDR_W-1:0] pend_addr;
  logic [WORD_W-1:0] pend_data;
  logic [LANES-1:0]  pend_mask;
  logic [WORD_W-1:0] arr_word, rd_word;
  logic [WORD_W-1:0] rd_q;
  logic              rd_vld_q;

  sbs_capture #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_cap (
    .clk_i, .rst_ni, .addr_i, .din_i, .sel_a_n_i, .sel_b_n_i, .sel_c_i,
    .gw_n_i, .bwe_n_i, .lane_we_n_i,
    .addr_q_o(addr_q), .din_q_o(din_q), .wmask_q_o(wmask_q), .cmd_q_o(cmd_q)
  );

  sbs_wbuf #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_wbuf (
    .clk_i, .rst_ni,
    .load_i(cmd_q == CMD_WRITE), .addr_i(addr_q), .data_i(din_q), .mask_i(wmask_q),
    .pend_vld_o(pend_vld), .pend_addr_o(pend_addr), .pend_data_o(pend_data),
    .pend_mask_o(pend_mask),
    .rd_addr_i(addr_q), .arr_word_i(arr_word), .rd_word_o(rd_word)
  );

  sbs_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
    .clk_i, .we_i(pend_vld), .waddr_i(pend_addr), .wdata_i(pend_data),
    .wmask_i(pend_mask), .raddr_i(addr_q), .rdata_o(arr_word)
  );

  // output register only moves on a selected read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q     <= '0;
      rd_vld_q <= 1'b0;
    end else begin
      rd_vld_q <= (cmd_q == CMD_READ);
      if (cmd_q == CMD_READ) rd_q <= rd_word;
    end
  end

  assign dout_o    = rd_q;
  assign dout_en_o = rd_vld_q && !oe_n_i;
endmodule

// File: rtl/sbs_chk.sv
module sbs_chk #(
  parameter int WORD_W = 18
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sel_a_n_i,
  input logic              sel_b_n_i,
  input logic              sel_c_i,
  input logic              gw_n_i,
  input logic              bwe_n_i,
  input logic              oe_n_i,
  input logic [WORD_W-1:0] dout_o,
  input logic              dout_en_o
);
  logic sel_in;
  assign sel_in = !sel_a_n_i && !sel_b_n_i && sel_c_i;

  // R8
  desel_float_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_in |=> ##1 !dout_en_o);

  // R9
  write_float_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_in && !gw_n_i) |=> ##1 !dout_en_o);

  // R9
  write_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_in && !gw_n_i) |=> ##1 $stable(dout_o));

  // R5
  read_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_in && gw_n_i && bwe_n_i) |=> ##1 (dout_en_o || oe_n_i));

  // R10
  always_comb begin
    if (rst_ni && oe_n_i) oe_gate_chk: assert (!dout_en_o);
  end
endmodule

bind sync_burst_sram sbs_chk #(.WORD_W(WORD_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sel_a_n_i(sel_a_n_i), .sel_b_n_i(sel_b_n_i),
  .sel_c_i(sel_c_i), .gw_n_i(gw_n_i), .bwe_n_i(bwe_n_i), .oe_n_i(oe_n_i),
  .dout_o(dout_o), .dout_en_o(dout_en_o)
);

// File: tb/sync_burst_sram_test.sv
module sync_burst_sram_test;
  localparam int CLK_P = 10;
  localparam int AW = 4;
  localparam int N = 1 << AW;
  localparam int WW = 18;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [WW-1:0] din_i = '0;
  logic sel_a_n_i = 1'b1, sel_b_n_i = 1'b1, sel_c_i = 1'b0;
  logic gw_n_i = 1'b1, bwe_n_i = 1'b1;
  logic [1:0] lane_we_n_i = 2'b11;
  logic oe_n_i = 1'b0;
  logic [WW-1:0] dout_o;
  logic dout_en_o;

  int checks = 0;
  int failures = 0;

  logic [WW-1:0] mem_m [N];
  logic [WW-1:0] last_rd = '0;
  logic e1_rd = 1'b0, e2_rd = 1'b0;
  logic [WW-1:0] e1_d = '0, e2_d = '0;
  string e1_t = "R1", e2_t = "R1";

  always #(CLK_P/2) clk = ~clk;

  sync_burst_sram #(.ADDR_W(AW)) uut (
    .clk_i(clk), .rst_ni, .addr_i, .din_i, .sel_a_n_i, .sel_b_n_i, .sel_c_i,
    .gw_n_i, .bwe_n_i, .lane_we_n_i, .oe_n_i, .dout_o, .dout_en_o
  );

  function automatic logic [WW-1:0] pat(input int a, input int s);
    return WW'((a * 18'h0b3d5 + s * 18'h1e2c7 + 18'h2a51) ^ (a << 9));
  endfunction

  task automatic chk1(input string t, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s act=%0b exp=%0b", t, what, act, exp);
    end
  endtask

  task automatic chkw(input string t, input logic [WW-1:0] act, input logic [WW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s dout act=%h exp=%h", t, act, exp);
    end
  endtask

  task automatic step(input logic an, input logic bn, input logic c, input logic gn,
                      input logic bw, input logic [1:0] ln, input logic [AW-1:0] a,
                      input logic [WW-1:0] d, input string t);
    logic sel;
    logic [1:0] m;
    @(negedge clk);
    chk1(e2_t, dout_en_o, e2_rd && !oe_n_i, "dout_en");
    chkw(e2_t, dout_o, e2_d);
    e2_rd = e1_rd; e2_d = e1_d; e2_t = e1_t;
    sel = !an && !bn && c;
    m = !sel ? 2'b00 : (!gn ? 2'b11 : (!bw ? ~ln : 2'b00));
    if (sel && m == 2'b00) begin
      last_rd = mem_m[a];
      e1_rd = 1'b1;
      e1_t = t;
    end else begin
      e1_rd = 1'b0;
      e1_t = (m != 2'b00) ? "R9" : t;
    end
    e1_d = last_rd;
    if (m[0]) mem_m[a][8:0] = d[8:0];
    if (m[1]) mem_m[a][17:9] = d[17:9];
    sel_a_n_i = an; sel_b_n_i = bn; sel_c_i = c;
    gw_n_i = gn; bwe_n_i = bw; lane_we_n_i = ln;
    addr_i = a; din_i = d;
    @(posedge clk);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [WW-1:0] d, input logic gn,
                    input logic bw, input logic [1:0] ln, input string t);
    step(1'b0, 1'b0, 1'b1, gn, bw, ln, a, d, t);
  endtask

  task automatic rd(input logic [AW-1:0] a, input string t);
    step(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 2'b11, a, '0, t);
  endtask

  task automatic idle(input string t);
    step(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 2'b11, '0, '0, t);
  endtask

  initial begin
    #(CLK_P * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1
    chk1("R1", dout_en_o, 1'b0, "dout_en");
    chkw("R1", dout_o, '0);
    rst_ni = 1'b1;

    // R4: global write with lane enables off
    for (int a = 0; a < N; a++) wr(AW'(a), pat(a, 0), 1'b0, 1'b1, 2'b11, "R4");
    for (int a = 0; a < N; a++) rd(AW'(a), "R4");

    // R2 / R3: every lane enable and byte-write combination
    for (int a = 0; a < N; a++)
      wr(AW'(a), pat(a, 1), 1'b1, a[2], a[1:0], a[2] ? "R3" : "R2");
    for (int a = 0; a < N; a++) rd(AW'(a), a[2] ? "R3" : "R2");

    // R4: global write overrides byte-write enable and lane enables
    for (int a = 0; a < N; a++) begin
      wr(AW'(a), pat(a, 2), 1'b0, a[0], a[2:1], "R4");
      idle("R8");
      rd(AW'(a), "R4");
    end

    // R6: pass-through on the same address, merged per lane
    for (int a = 0; a < N; a++) begin
      wr(AW'(a), pat(a, 3), 1'b1, 1'b0, a[1:0], "R6");
      rd(AW'(a), "R6");
    end
    // R6: neighbouring address must not be forwarded
    for (int a = 0; a < N; a++) begin
      wr(AW'(a), pat(a, 4), 1'b1, 1'b0, 2'b00, "R6");
      rd(AW'(a ^ 1), "R6");
    end
    // R6: two writes in a row, then read of both
    wr(AW'(3), pat(3, 5), 1'b1, 1'b0, 2'b10, "R6");
    wr(AW'(3), pat(3, 6), 1'b1, 1'b0, 2'b01, "R6");
    rd(AW'(3), "R6");

    // R7 / R8: drop each select in turn during writes and reads
    for (int k = 0; k < 3; k++) begin
      for (int a = 0; a < 4; a++) begin
        step(k == 0, k == 1, k != 2, 1'b0, 1'b0, 2'b00, AW'(a), pat(a, 7), "R7");
        step(k == 0, k == 1, k != 2, 1'b1, 1'b1, 2'b11, AW'(a), '0, "R8");
      end
    end
    for (int a = 0; a < 4; a++) rd(AW'(a), "R7");

    // R5: back-to-back burst beats
    for (int a = 8; a < 12; a++) rd(AW'(a), "R5");

    // R10: asynchronous output enable between edges
    rd(AW'(5), "R10");
    idle("R8");
    #(CLK_P/4);
    oe_n_i = 1'b1;
    #1 chk1("R10", dout_en_o, 1'b0, "dout_en oe high");
    oe_n_i = 1'b0;
    #1 chk1("R10", dout_en_o, 1'b1, "dout_en oe low");

    repeat (3) idle("R8");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule